// File: doc/BRIEF.md
# Filtered Fault Latch with Manual Clear

This block guards one pulse output against an external fault. The active-high fault line is first brought into the clock domain. It is then checked by a sampling filter that looks at it once every programmable number of clocks. A change in level is accepted only after a programmable number of consecutive samples agree with it. When the map enable is on and the filtered fault is high, a status flag latches. While the flag is set, the protected output is forced to its safe level, which defaults to low, and the run permit is withdrawn.

Recovery is manual only. The flag stays set after the fault goes away and falls only when software pulses the clear strobe. A clear that arrives while the filtered fault is still high is ignored. With the map enable off, the fault line cannot set the flag, so an unused fault input cannot stop the output. An external output-disable input also holds the output at its safe level and withdraws the run permit, but it does not touch the flag.

Top module: `fault_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), fault_flag and force_safe are 0, the filter holds the no-fault level, and run_permit is 1 when out_disable is 0.
- R2: Counting the first clock edge with rst_n high as edge 1, the filter samples at edges n where n mod P = 0, with P = samp_period (a value of 0 acts as 1). The value it samples is fault_in as it stood two edges earlier: a level set up before edge a is first seen by the sample at edge a+2.
- R3: With map_en = 1, the filtered level rises at the edge of the N-th consecutive high sample, with N = samp_count (a value of 0 acts as 1). fault_flag rises at the next edge.
- R4: A high fault that is seen by fewer than N consecutive samples leaves fault_flag at 0.
- R5: While map_en = 0, fault_flag cannot set. If map_en goes to 1 while the filtered level is high, fault_flag sets at the next edge.
- R6: Once set, fault_flag stays at 1 after fault_in returns low, until it is cleared.
- R7: clr_pulse is ignored at any edge where map_en is 1 and the filtered level is still high, including the edge at which the filtered level falls.
- R8: clr_pulse at an edge where the filtered level is low clears fault_flag at that edge.
- R9: force_safe equals fault_flag. pulse_out equals the SAFE_LEVEL parameter (default 0) whenever force_safe or out_disable is 1, and equals pulse_in otherwise.
- R10: run_permit is 1 exactly when fault_flag is 0 and out_disable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_in | input | 1 | Raw fault line, active high, asynchronous |
| samp_period | input | 8 | Clocks between filter samples (0 acts as 1) |
| samp_count | input | 3 | Consecutive agreeing samples needed (0 acts as 1) |
| map_en | input | 1 | Connects the filtered fault to the latch |
| clr_pulse | input | 1 | Software clear strobe for the fault flag |
| out_disable | input | 1 | External output-disable state |
| pulse_in | input | 1 | Pulse from the generator |
| pulse_out | output | 1 | Protected pulse output |
| fault_flag | output | 1 | Latched fault status |
| force_safe | output | 1 | Output is being held at its safe level because of a fault |
| run_permit | output | 1 | The output may run |

## Verification
Every sample edge falls at a fixed edge number counted from reset release. The bench therefore counts edges and finds the first sample edge at or after the edge where a fault level lands plus two synchronizer edges. It expects the filtered level to change N−1 sample periods after that, and fault_flag to rise one edge later. Clears are placed on the exact edge where the filtered level falls and on the edge after it, which tests the boundary between ignored and accepted. The flag, force and permit outputs are sampled on the falling clock edge after the rising edge at which each one is due. The combinational outputs are checked in the same half cycle as their inputs.

// File: rtl/fg_pkg.sv
// Shared definitions for the fault guard.
// Assumes: the filter level is stored as a named two-state enum.
package fg_pkg;
    typedef enum logic {
        LVL_QUIET = 1'b0,
        LVL_FAULT = 1'b1
    } flt_lvl_e;

    localparam int unsigned FG_SYNC_DEFAULT = 2;
endpackage

// File: rtl/fg_sync.sv
// Multi-stage synchronizer for the asynchronous fault line.
// Assumes: STAGES >= 1; resets to the no-fault level.
module fg_sync #(
    parameter int unsigned STAGES = fg_pkg::FG_SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            // Shift the raw level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fg_tick.sv
// Sample-strobe generator: one strobe every max(period,1) clocks.
// Assumes: the counter starts at 0 out of reset, so strobes fall on
// edges n with n mod P == 0 counted from reset release.
module fg_tick #(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period,
    output logic          tick
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] p_eff;

    // Effective period: zero behaves as one.
    always_comb p_eff = (period == '0) ? PW'(1) : period;

    // Strobe when the count reaches the last slot (>= tolerates a shrinking period).
    always_comb tick = (cnt_q >= (p_eff - PW'(1)));

    // Advance or wrap the prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + PW'(1);
    end

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/fg_filter.sv
// Consecutive-sample filter: the level flips after N samples that disagree with it.
// Assumes: one sample per tick; an agreeing sample restarts the run count.
module fg_filter #(
    parameter int unsigned CW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            sample,
    input  logic [CW-1:0]   need,
    output fg_pkg::flt_lvl_e lvl
);
    import fg_pkg::*;

    flt_lvl_e      lvl_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] n_eff;
    logic [CW:0]   run_next;
    logic          disagree;

    // Effective requirement: zero behaves as one.
    always_comb n_eff = (need == '0) ? CW'(1) : need;
    // Length of the run if this sample also disagrees.
    always_comb run_next = {1'b0, run_q} + (CW+1)'(1);
    // Sample differs from the held level.
    always_comb disagree = (sample != lvl_q);

    // Update the held level and the run of disagreeing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_QUIET;
            run_q <= '0;
        end else if (tick) begin
            if (!disagree) begin
                run_q <= '0;
            end else if (run_next >= {1'b0, n_eff}) begin
                lvl_q <= flt_lvl_e'(sample);
                run_q <= '0;
            end else begin
                run_q <= run_next[CW-1:0];
            end
        end
    end

    assign lvl = lvl_q;

    a_r3_level_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> $past(tick));
    a_r4_agree_restarts_run: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !disagree) |=> (run_q == '0));
endmodule

// File: rtl/fg_latch.sv
// Fault status latch with manual clear and map gating.
// Assumes: set wins over clear; clear is refused while the mapped fault is high.
module fg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic map_en,
    input  logic filt_hi,
    input  logic clr,
    output logic flag
);
    logic mapped;
    logic flag_q;

    // Fault as seen through the map.
    always_comb mapped = map_en & filt_hi;

    // Set on a mapped fault, clear only when the mapped fault is gone.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (mapped) flag_q <= 1'b1;
        else if (clr)    flag_q <= 1'b0;
    end

    assign flag = flag_q;

    a_r5_unmapped_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_en && !flag_q) |=> !flag_q);
    a_r3_mapped_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en && filt_hi) |=> flag_q);
    a_r7_clear_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clr && map_en && filt_hi) |=> flag_q);
    a_r8_clear_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(map_en && filt_hi)) |=> !flag_q);
    a_r6_holds_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/fault_guard.sv
// Fault guard for one pulse output: synchronizer, sample strobe, consecutive
// sample filter, mapped latch with manual clear, and output forcing.
// Assumes: fault_in is active high and asynchronous; SAFE_LEVEL is the forced level.
module fault_guard #(
    parameter int unsigned PERIOD_W    = 8,
    parameter int unsigned COUNT_W     = 3,
    parameter int unsigned SYNC_STAGES = fg_pkg::FG_SYNC_DEFAULT,
    parameter bit          SAFE_LEVEL  = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fault_in,
    input  logic [PERIOD_W-1:0] samp_period,
    input  logic [COUNT_W-1:0]  samp_count,
    input  logic                map_en,
    input  logic                clr_pulse,
    input  logic                out_disable,
    input  logic                pulse_in,
    output logic                pulse_out,
    output logic                fault_flag,
    output logic                force_safe,
    output logic                run_permit
);
    import fg_pkg::*;

    logic     fault_s;
    logic     tick;
    flt_lvl_e lvl;
    logic     flag;

    fg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fault_in),
        .q     (fault_s)
    );

    fg_tick #(.PW(PERIOD_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (samp_period),
        .tick   (tick)
    );

    fg_filter #(.CW(COUNT_W)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .sample (fault_s),
        .need   (samp_count),
        .lvl    (lvl)
    );

    fg_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .map_en  (map_en),
        .filt_hi (lvl == LVL_FAULT),
        .clr     (clr_pulse),
        .flag    (flag)
    );

    // Drive status, permit and the protected output.
    always_comb begin
        fault_flag = flag;
        force_safe = flag;
        run_permit = ~flag & ~out_disable;
        pulse_out  = (flag | out_disable) ? SAFE_LEVEL : pulse_in;
    end

    a_r10_permit_excludes_force: assert property (@(posedge clk) disable iff (!rst_n)
        run_permit |-> (!force_safe && !out_disable));
    a_r9_forced_level: assert property (@(posedge clk) disable iff (!rst_n)
        force_safe |-> (pulse_out == SAFE_LEVEL));
endmodule

// File: tb/fault_guard_tb.sv
module fault_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault_in = 1'b0;
    logic [7:0] samp_period = 8'd1;
    logic [2:0] samp_count = 3'd1;
    logic       map_en = 1'b1;
    logic       clr_pulse = 1'b0;
    logic       out_disable = 1'b0;
    logic       pulse_in = 1'b1;
    logic       pulse_out, fault_flag, force_safe, run_permit;

    int edge_n = 0;
    int n_chk = 0;
    int n_bad = 0;
    int wd = 0;

    fault_guard u_dut (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in),
        .samp_period(samp_period), .samp_count(samp_count),
        .map_en(map_en), .clr_pulse(clr_pulse), .out_disable(out_disable),
        .pulse_in(pulse_in), .pulse_out(pulse_out), .fault_flag(fault_flag),
        .force_safe(force_safe), .run_permit(run_permit)
    );

    always #2.5 clk = ~clk;

    // Edge numbering: edge 1 is the first rising edge with rst_n high.
    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    task automatic neg();
        @(negedge clk);
    endtask

    function automatic int ceil_mult(input int x, input int p);
        return ((x + p - 1) / p) * p;
    endfunction

    task automatic do_reset(input int p, input int n);
        neg();
        rst_n = 1'b0; fault_in = 1'b0; clr_pulse = 1'b0; map_en = 1'b1;
        out_disable = 1'b0; pulse_in = 1'b1;
        samp_period = 8'(p); samp_count = 3'(n);
        neg(); neg();
        rst_n = 1'b1;
        // R1: reset state seen before the first counted edge
        check(fault_flag == 1'b0, "R1 flag", int'(fault_flag), 0);
        check(run_permit == 1'b1, "R1 permit", int'(run_permit), 1);
        check(pulse_out == 1'b1, "R1 pass-through", int'(pulse_out), 1);
    endtask

    task automatic run_cfg(input int p, input int n);
        int pe, ne, a, t1, drop_a, exp_e, first_e, tf;
        pe = (p == 0) ? 1 : p;
        ne = (n == 0) ? 1 : n;
        do_reset(p, n);
        for (int i = 0; i < (pe + ne) % 3; i++) neg();

        // R4: a pulse seen by only N-1 samples is rejected
        if (ne >= 2) begin
            a = edge_n + 1;
            fault_in = 1'b1;
            t1 = ceil_mult(a + 2, pe);
            drop_a = t1 + (ne - 2) * pe - 1;
            while (edge_n < drop_a - 1) neg();
            fault_in = 1'b0;
            for (int i = 0; i < (ne + 2) * pe + 4; i++) begin
                neg();
                if (fault_flag) break;
            end
            check(fault_flag == 1'b0, "R4 glitch rejected", int'(fault_flag), 0);
        end

        // R2, R3: exact edge at which the flag rises
        a = edge_n + 1;
        fault_in = 1'b1;
        exp_e = ceil_mult(a + 2, pe) + (ne - 1) * pe + 1;
        first_e = -1;
        while (edge_n < exp_e + 2) begin
            neg();
            if (fault_flag && first_e < 0) first_e = edge_n;
        end
        check(first_e == exp_e, "R2/R3 flag rise edge", first_e, exp_e);
        check(force_safe == 1'b1, "R9 force", int'(force_safe), 1);
        check(pulse_out == 1'b0, "R9 safe level", int'(pulse_out), 0);
        check(run_permit == 1'b0, "R10 permit withdrawn", int'(run_permit), 0);

        // R7: clear while the fault is still qualified
        clr_pulse = 1'b1; neg(); clr_pulse = 1'b0;
        check(fault_flag == 1'b1, "R7 clear refused", int'(fault_flag), 1);

        // R6, R7, R8: fault removed, clear at the falling edge and the one after
        a = edge_n + 1;
        fault_in = 1'b0;
        tf = ceil_mult(a + 2, pe) + (ne - 1) * pe;
        while (edge_n < tf - 1) neg();
        check(fault_flag == 1'b1, "R6 latched", int'(fault_flag), 1);
        clr_pulse = 1'b1;
        neg();
        check(fault_flag == 1'b1, "R7 clear at fall edge", int'(fault_flag), 1);
        neg();
        clr_pulse = 1'b0;
        check(fault_flag == 1'b0, "R8 clear taken", int'(fault_flag), 0);
        check(run_permit == 1'b1, "R10 permit back", int'(run_permit), 1);

        // R9, R10: output-disable path
        out_disable = 1'b1; #1;
        check(run_permit == 1'b0, "R10 disabled", int'(run_permit), 0);
        check(pulse_out == 1'b0, "R9 disabled level", int'(pulse_out), 0);
        out_disable = 1'b0; pulse_in = 1'b0; #1;
        check(pulse_out == 1'b0, "R9 follow low", int'(pulse_out), 0);
        pulse_in = 1'b1; #1;
        check(pulse_out == 1'b1, "R9 follow high", int'(pulse_out), 1);

        // R5: map disabled, then enabled with the fault still qualified
        neg();
        map_en = 1'b0;
        fault_in = 1'b1;
        for (int i = 0; i < (ne + 2) * pe + 6; i++) neg();
        check(fault_flag == 1'b0, "R5 unmapped", int'(fault_flag), 0);
        check(run_permit == 1'b1, "R5 permit kept", int'(run_permit), 1);
        map_en = 1'b1;
        neg();
        check(fault_flag == 1'b1, "R5 map on sets", int'(fault_flag), 1);
    endtask

    initial begin
        for (int p = 0; p <= 4; p++)
            for (int n = 0; n <= 7; n++)
                run_cfg(p, n);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end
endmodule